// File: doc/BRIEF.md
# Tagged Zero-Block Operation Trap Router

This block sits in the system-instruction decode path of a processor core. It looks at each system-instruction request and picks out one encoding: the cache operation that zeroes a block of memory and writes its allocation tags. For that encoding it decides what happens next. The instruction either runs, traps to privilege level 1, traps to privilege level 2, or is undefined. The decision uses the current privilege level, whether the memory-tagging feature is built in, and a small set of trap and enable controls.

A request is presented with `req_valid` high for one cycle, together with the five encoding fields and the privilege context. One cycle later the block drives exactly one of `do_exec`, `do_trap` or `do_undef` high for one cycle. It drives none of them if the encoding is some other instruction. Any trap reports a target level and a fixed 6-bit exception class. There is no back-pressure: the core may issue a request in every cycle, and each one gets its own registered answer. Carrying out the zeroing is left to the load/store path.

The privilege-level-0 rules are checked in a fixed order, and the first one that fires picks the outcome:
1. The level-1 zero enable.
2. The level-2 zero trap.
3. The level-2 zero enable, which only applies in host mode.

Host mode means level 2 is enabled and both `host_mode_en` and `guest_route_lvl2` are 1.

Top module: `zva_trap_router`

## Requirements
- R1: A request is recognised only when op0=2'b01, op1=3'b011, CRn=4'b0111, CRm=4'b0100 and op2=3'b100. For any other encoding, all three outcome strobes stay low in the following cycle.
- R2: For a recognised request with `tag_feat_present`=0, `do_undef` goes high in the following cycle, whatever the level or controls.
- R3: Outputs are registered and appear in the cycle after `req_valid` is sampled high. With `req_valid` low, every strobe is low in the next cycle and the class and level outputs are zero. A recognised request raises exactly one strobe, and consecutive requests are each answered.
- R4: At level 0, the first rule fires when level 1 is 64-bit, host mode is off and `lvl1_zero_allow`=0. It traps to level 2 if level 2 is enabled, level 2 is 64-bit and `guest_route_lvl2`=1; otherwise it traps to level 1. This rule takes priority over R5 and R6.
- R5: At level 0, if R4 did not fire, the request traps to level 2 when all of these hold: level 2 is enabled, level 2 is 64-bit, {`host_mode_en`,`guest_route_lvl2`} is not 2'b11, and `lvl2_zero_trap`=1.
- R6: At level 0, if neither R4 nor R5 fired, the request traps to level 2 when all of these hold: level 2 is enabled, level 2 is 64-bit, {`host_mode_en`,`guest_route_lvl2`} is 2'b11, and `lvl2_zero_allow`=0. If this rule does not fire either, the request executes.
- R7: At level 1, the request traps to level 2 when level 2 is enabled, level 2 is 64-bit and `lvl2_zero_trap`=1. Otherwise it executes.
- R8: At levels 2 and 3 a recognised request with the feature present always executes.
- R9: A trap drives `trap_class`=6'h18. `trap_lvl` is 2'd1 for a level-1 target and 2'd2 for a level-2 target. Both are zero whenever `do_trap` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A system-instruction request is present this cycle |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| tag_feat_present | input | 1 | Memory-tagging feature is built in |
| lvl2_enabled | input | 1 | Privilege level 2 is enabled |
| lvl1_is_32bit | input | 1 | Level 1 runs in the 32-bit execution state |
| lvl2_is_32bit | input | 1 | Level 2 runs in the 32-bit execution state |
| lvl1_zero_allow | input | 1 | Level-1 control allowing block zeroing from level 0 |
| lvl2_zero_allow | input | 1 | Level-2 control allowing block zeroing from level 0 in host mode |
| host_mode_en | input | 1 | Level-2 host-operating-system mode select |
| guest_route_lvl2 | input | 1 | Route level-0 exceptions to level 2 |
| lvl2_zero_trap | input | 1 | Trap block zeroing from levels 0 and 1 to level 2 |
| do_exec | output | 1 | Recognised request executes |
| do_trap | output | 1 | Recognised request traps |
| trap_lvl | output | 2 | Trap target level, zero when not trapping |
| trap_class | output | 6 | Exception class of the trap, zero when not trapping |
| do_undef | output | 1 | Recognised request is undefined |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one clock edge before the first request.
- The encoding fields and context flags are settled at the sampling edge whenever `req_valid` is high.
- `cur_lvl` only ever carries its four legal values.

They make no assumption about the inputs while `req_valid` is low. The bench changes inputs only on the falling clock edge and holds them for a whole cycle. It issues requests both one at a time and back to back, which exercises the rules that each request gets its own answer and that an idle cycle produces nothing.

// File: rtl/zr_pkg.sv
package zr_pkg;
  localparam int OP0_W = 2;
  localparam int OP1_W = 3;
  localparam int CRN_W = 4;
  localparam int CRM_W = 4;
  localparam int OP2_W = 3;
  localparam int LVL_W = 2;
  localparam int CLS_W = 6;

  localparam logic [LVL_W-1:0] LVL0 = 2'd0;
  localparam logic [LVL_W-1:0] LVL1 = 2'd1;
  localparam logic [LVL_W-1:0] LVL2 = 2'd2;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_EXEC  = 2'd1,
    OUT_TRAP  = 2'd2,
    OUT_UNDEF = 2'd3
  } zr_kind_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             l2_on;
    logic             l1_narrow;
    logic             l2_narrow;
    logic             l1_allow;
    logic             l2_allow;
    logic             host_mode;
    logic             guest_route;
    logic             l2_trap_zero;
  } zr_ctx_t;

  typedef struct packed {
    zr_kind_e         kind;
    logic [LVL_W-1:0] tlvl;
  } zr_result_t;
endpackage

// File: rtl/zr_decode.sv
module zr_decode
  import zr_pkg::*;
#(
  parameter logic [OP0_W-1:0] MATCH_OP0 = 2'b01,
  parameter logic [OP1_W-1:0] MATCH_OP1 = 3'b011,
  parameter logic [CRN_W-1:0] MATCH_CRN = 4'b0111,
  parameter logic [CRM_W-1:0] MATCH_CRM = 4'b0100,
  parameter logic [OP2_W-1:0] MATCH_OP2 = 3'b100
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int NFIELD = 5;
  logic [NFIELD-1:0] field_eq;

  always_comb begin
    field_eq[0] = (op0 == MATCH_OP0);
    field_eq[1] = (op1 == MATCH_OP1);
    field_eq[2] = (crn == MATCH_CRN);
    field_eq[3] = (crm == MATCH_CRM);
    field_eq[4] = (op2 == MATCH_OP2);
    hit         = &field_eq;
  end
endmodule

// File: rtl/zr_route.sv
module zr_route
  import zr_pkg::*;
(
  input  logic       hit,
  input  logic       feat_present,
  input  zr_ctx_t    ctx,
  output zr_result_t res
);
  logic l2_wide;
  logic pair_set;
  logic host_on;

  always_comb begin
    l2_wide  = ctx.l2_on && !ctx.l2_narrow;
    pair_set = ctx.host_mode && ctx.guest_route;
    host_on  = ctx.l2_on && pair_set;
  end

  always_comb begin
    res.kind = OUT_NONE;
    res.tlvl = '0;
    if (hit) begin
      if (!feat_present) begin
        res.kind = OUT_UNDEF;
      end else begin
        case (ctx.lvl)
          LVL0: begin
            if (!ctx.l1_narrow && !host_on && !ctx.l1_allow) begin
              res.kind = OUT_TRAP;
              res.tlvl = (l2_wide && ctx.guest_route) ? LVL2 : LVL1;
            end else if (l2_wide && !pair_set && ctx.l2_trap_zero) begin
              res.kind = OUT_TRAP;
              res.tlvl = LVL2;
            end else if (l2_wide && pair_set && !ctx.l2_allow) begin
              res.kind = OUT_TRAP;
              res.tlvl = LVL2;
            end else begin
              res.kind = OUT_EXEC;
            end
          end
          LVL1: begin
            if (l2_wide && ctx.l2_trap_zero) begin
              res.kind = OUT_TRAP;
              res.tlvl = LVL2;
            end else begin
              res.kind = OUT_EXEC;
            end
          end
          default: res.kind = OUT_EXEC;
        endcase
      end
    end
  end
endmodule

// File: rtl/zr_outreg.sv
module zr_outreg
  import zr_pkg::*;
#(
  parameter logic [CLS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  zr_result_t       res,
  output logic             do_exec,
  output logic             do_trap,
  output logic [LVL_W-1:0] trap_lvl,
  output logic [CLS_W-1:0] trap_class,
  output logic             do_undef
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      do_exec    <= 1'b0;
      do_trap    <= 1'b0;
      do_undef   <= 1'b0;
      trap_lvl   <= '0;
      trap_class <= '0;
    end else begin
      do_exec    <= req_valid && (res.kind == OUT_EXEC);
      do_trap    <= req_valid && (res.kind == OUT_TRAP);
      do_undef   <= req_valid && (res.kind == OUT_UNDEF);
      trap_lvl   <= (req_valid && res.kind == OUT_TRAP) ? res.tlvl : '0;
      trap_class <= (req_valid && res.kind == OUT_TRAP) ? TRAP_CLASS : '0;
    end
  end

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(do_exec || do_trap || do_undef));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && res.kind != OUT_NONE) |=> ($countones({do_exec, do_trap, do_undef}) == 1));

  assert_trap_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_trap |-> (trap_class == TRAP_CLASS && (trap_lvl == LVL1 || trap_lvl == LVL2)));

  assert_quiet_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !do_trap |-> (trap_class == '0 && trap_lvl == '0));
endmodule

// File: rtl/zva_trap_router.sv
module zva_trap_router
  import zr_pkg::*;
#(
  parameter logic [CLS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OP0_W-1:0] enc_op0,
  input  logic [OP1_W-1:0] enc_op1,
  input  logic [CRN_W-1:0] enc_crn,
  input  logic [CRM_W-1:0] enc_crm,
  input  logic [OP2_W-1:0] enc_op2,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             tag_feat_present,
  input  logic             lvl2_enabled,
  input  logic             lvl1_is_32bit,
  input  logic             lvl2_is_32bit,
  input  logic             lvl1_zero_allow,
  input  logic             lvl2_zero_allow,
  input  logic             host_mode_en,
  input  logic             guest_route_lvl2,
  input  logic             lvl2_zero_trap,
  output logic             do_exec,
  output logic             do_trap,
  output logic [LVL_W-1:0] trap_lvl,
  output logic [CLS_W-1:0] trap_class,
  output logic             do_undef
);
  logic       hit;
  zr_ctx_t    ctx;
  zr_result_t res;

  always_comb begin
    ctx.lvl          = cur_lvl;
    ctx.l2_on        = lvl2_enabled;
    ctx.l1_narrow    = lvl1_is_32bit;
    ctx.l2_narrow    = lvl2_is_32bit;
    ctx.l1_allow     = lvl1_zero_allow;
    ctx.l2_allow     = lvl2_zero_allow;
    ctx.host_mode    = host_mode_en;
    ctx.guest_route  = guest_route_lvl2;
    ctx.l2_trap_zero = lvl2_zero_trap;
  end

  zr_decode u_decode (
    .op0 (enc_op0),
    .op1 (enc_op1),
    .crn (enc_crn),
    .crm (enc_crm),
    .op2 (enc_op2),
    .hit (hit)
  );

  zr_route u_route (
    .hit          (hit),
    .feat_present (tag_feat_present),
    .ctx          (ctx),
    .res          (res)
  );

  zr_outreg #(.TRAP_CLASS(TRAP_CLASS)) u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .res        (res),
    .do_exec    (do_exec),
    .do_trap    (do_trap),
    .trap_lvl   (trap_lvl),
    .trap_class (trap_class),
    .do_undef   (do_undef)
  );

  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> !(do_exec || do_trap || do_undef));

  assert_no_feat_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !tag_feat_present) |=> do_undef);

  assert_lvl1_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_lvl == LVL1) |=> !(do_trap && trap_lvl != LVL2));

  assert_high_lvl_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && tag_feat_present && cur_lvl[1]) |=> do_exec);
endmodule

// File: tb/tb_zva_trap_router.sv
`timescale 1ns/1ps
module tb_zva_trap_router;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] enc_op0;
  logic [2:0] enc_op1;
  logic [3:0] enc_crn;
  logic [3:0] enc_crm;
  logic [2:0] enc_op2;
  logic [1:0] cur_lvl;
  logic       tag_feat_present, lvl2_enabled, lvl1_is_32bit, lvl2_is_32bit;
  logic       lvl1_zero_allow, lvl2_zero_allow, host_mode_en, guest_route_lvl2, lvl2_zero_trap;
  logic       do_exec, do_trap, do_undef;
  logic [1:0] trap_lvl;
  logic [5:0] trap_class;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  zva_trap_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn), .enc_crm(enc_crm), .enc_op2(enc_op2),
    .cur_lvl(cur_lvl), .tag_feat_present(tag_feat_present), .lvl2_enabled(lvl2_enabled),
    .lvl1_is_32bit(lvl1_is_32bit), .lvl2_is_32bit(lvl2_is_32bit),
    .lvl1_zero_allow(lvl1_zero_allow), .lvl2_zero_allow(lvl2_zero_allow),
    .host_mode_en(host_mode_en), .guest_route_lvl2(guest_route_lvl2), .lvl2_zero_trap(lvl2_zero_trap),
    .do_exec(do_exec), .do_trap(do_trap), .trap_lvl(trap_lvl), .trap_class(trap_class), .do_undef(do_undef)
  );

  task automatic set_match();
    enc_op0 = 2'b01; enc_op1 = 3'b011; enc_crn = 4'b0111; enc_crm = 4'b0100; enc_op2 = 3'b100;
  endtask

  // lvl, feat, l2 enabled, l1 32-bit, l2 32-bit, l1 allow, l2 allow, host mode, route, l2 trap
  task automatic set_ctx(input logic [1:0] lv, input logic ft, input logic en2, input logic n1,
                         input logic n2, input logic a1, input logic a2, input logic hm,
                         input logic gr, input logic tz);
    cur_lvl = lv; tag_feat_present = ft; lvl2_enabled = en2; lvl1_is_32bit = n1;
    lvl2_is_32bit = n2; lvl1_zero_allow = a1; lvl2_zero_allow = a2; host_mode_en = hm;
    guest_route_lvl2 = gr; lvl2_zero_trap = tz;
  endtask

  task automatic check(input string tag, input logic e_ex, input logic e_tr,
                       input logic [1:0] e_lv, input logic e_un);
    logic [5:0] e_cls;
    e_cls = e_tr ? 6'h18 : 6'h00;
    n_checks++;
    if (do_exec !== e_ex || do_trap !== e_tr || trap_lvl !== e_lv ||
        do_undef !== e_un || trap_class !== e_cls) begin
      n_fail++;
      $display("FAIL %s (R9 fields): got exec=%b trap=%b lvl=%0d cls=%h undef=%b, expected exec=%b trap=%b lvl=%0d cls=%h undef=%b",
               tag, do_exec, do_trap, trap_lvl, trap_class, do_undef, e_ex, e_tr, e_lv, e_cls, e_un);
    end
  endtask

  // Called at a falling edge with inputs set; result is sampled at the next falling edge.
  task automatic req_check(input string tag, input logic e_ex, input logic e_tr,
                           input logic [1:0] e_lv, input logic e_un);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, e_ex, e_tr, e_lv, e_un);
  endtask

  task automatic t_reset_idle();
    check("R3 reset state", 0, 0, 2'd0, 0);
    set_match(); set_ctx(2'd0, 1, 1, 0, 0, 0, 0, 0, 1, 1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 idle with matching encoding", 0, 0, 2'd0, 0);
  endtask

  task automatic t_encoding();
    set_ctx(2'd2, 1, 0, 0, 0, 1, 1, 0, 0, 0);
    set_match(); req_check("R1 matching encoding executes", 1, 0, 2'd0, 0);
    set_match(); enc_op0 = 2'b11; req_check("R1 op0 mismatch", 0, 0, 2'd0, 0);
    set_match(); enc_op1 = 3'b010; req_check("R1 op1 mismatch", 0, 0, 2'd0, 0);
    set_match(); enc_crn = 4'b0110; req_check("R1 CRn mismatch", 0, 0, 2'd0, 0);
    set_match(); enc_crm = 4'b0101; req_check("R1 CRm mismatch", 0, 0, 2'd0, 0);
    set_match(); enc_op2 = 3'b001; req_check("R1 op2 mismatch", 0, 0, 2'd0, 0);
    set_match(); enc_op0 = 2'b11; set_ctx(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    req_check("R1 foreign encoding without feature", 0, 0, 2'd0, 0);
    set_match();
  endtask

  task automatic t_feature();
    for (int lv = 0; lv < 4; lv++) begin
      set_ctx(lv[1:0], 0, 1, 0, 0, 0, 0, 0, 1, 1);
      req_check("R2 feature absent is undefined", 0, 0, 2'd0, 1);
    end
  endtask

  task automatic t_lvl0_first();
    set_ctx(2'd0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    req_check("R4 level-1 enable off, no level 2", 0, 1, 2'd1, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 0, 1, 0, 1, 0);
    req_check("R4 routed to level 2", 0, 1, 2'd2, 0);
    set_ctx(2'd0, 1, 1, 0, 1, 0, 1, 0, 1, 0);
    req_check("R4 level 2 is 32-bit, goes to level 1", 0, 1, 2'd1, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 0, 1, 0, 0, 1);
    req_check("R4 priority over level-2 trap", 0, 1, 2'd1, 0);
    set_ctx(2'd0, 1, 0, 1, 0, 0, 1, 0, 0, 0);
    req_check("R4 skipped when level 1 is 32-bit", 1, 0, 2'd0, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 1, 1, 0, 0, 0);
    req_check("R6 no rule fires, executes", 1, 0, 2'd0, 0);
  endtask

  task automatic t_lvl0_second();
    set_ctx(2'd0, 1, 1, 0, 0, 1, 1, 0, 0, 1);
    req_check("R5 level-2 trap at level 0", 0, 1, 2'd2, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 1, 1, 1, 0, 1);
    req_check("R5 host-mode bit alone still traps", 0, 1, 2'd2, 0);
    set_ctx(2'd0, 1, 0, 0, 0, 1, 1, 0, 0, 1);
    req_check("R5 ignored with level 2 disabled", 1, 0, 2'd0, 0);
    set_ctx(2'd0, 1, 1, 0, 1, 1, 1, 0, 0, 1);
    req_check("R5 ignored with level 2 32-bit", 1, 0, 2'd0, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 1, 1, 1, 1, 1);
    req_check("R5 skipped in host mode", 1, 0, 2'd0, 0);
  endtask

  task automatic t_lvl0_third();
    set_ctx(2'd0, 1, 1, 0, 0, 0, 0, 1, 1, 0);
    req_check("R6 host mode, level-2 enable off", 0, 1, 2'd2, 0);
    set_ctx(2'd0, 1, 1, 0, 0, 0, 1, 1, 1, 0);
    req_check("R6 host mode, level-2 enable on", 1, 0, 2'd0, 0);
    set_ctx(2'd0, 1, 1, 0, 1, 0, 0, 1, 1, 0);
    req_check("R6 host mode but level 2 32-bit", 1, 0, 2'd0, 0);
  endtask

  task automatic t_lvl1();
    set_ctx(2'd1, 1, 1, 0, 0, 0, 0, 0, 0, 1);
    req_check("R7 level-1 trap to level 2", 0, 1, 2'd2, 0);
    set_ctx(2'd1, 1, 1, 0, 1, 0, 0, 0, 0, 1);
    req_check("R7 level 2 32-bit executes", 1, 0, 2'd0, 0);
    set_ctx(2'd1, 1, 1, 0, 0, 0, 0, 1, 1, 0);
    req_check("R7 no trap bit executes", 1, 0, 2'd0, 0);
  endtask

  task automatic t_high();
    set_ctx(2'd2, 1, 1, 0, 0, 0, 0, 0, 1, 1);
    req_check("R8 level 2 executes", 1, 0, 2'd0, 0);
    set_ctx(2'd3, 1, 1, 0, 0, 0, 0, 1, 1, 1);
    req_check("R8 level 3 executes", 1, 0, 2'd0, 0);
  endtask

  task automatic t_back_to_back();
    set_ctx(2'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    req_valid = 1'b1;
    @(negedge clk);
    check("R3 first of pair", 0, 1, 2'd1, 0);
    set_ctx(2'd3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R3 second of pair", 1, 0, 2'd0, 0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 quiet after pair", 0, 0, 2'd0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    set_match(); set_ctx(2'd0, 1, 0, 0, 0, 1, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_encoding();
    t_feature();
    t_lvl0_first();
    t_lvl0_second();
    t_lvl0_third();
    t_lvl1();
    t_high();
    t_back_to_back();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule